// File: doc/BRIEF.md
# Duty Cycle Slew Controller

This block holds the duty value that a fan PWM generator consumes and moves it toward a requested target duty. The duty is an 8-bit code from 0 to 255, and one LSB is about 0.392 % of full scale. With slewing turned off, the held duty copies the target directly. With slewing turned on, the duty approaches the target in bounded steps, and each step is taken at a programmable interval.

The interval is derived from a base tick pulse that arrives every 1/16 s. A 3-bit rate code selects a divider of 2^(7−code) base ticks, so code 7 gives 1/16 s and code 0 gives 8 s. A 2-bit step code sets the size of each move. A 2-bit band code sets how close the duty must be to the target before it stops moving. A change of the rate code restarts the divider.

Top module: `duty_slew`

## Requirements
- R1: While reset is asserted, and after it is released, the duty output reads 0 until the first load or step.
- R2: With `rampEn` = 0, the duty equals `targetDuty` one clock edge after the target is presented. This needs no base tick.
- R3: With `rampEn` = 1, the duty changes only on the clock edge that samples an update base tick. It holds its value on every other edge.
- R4: With `rampEn` = 1 and rate code r, an update occurs on every 2^(7−r)-th base tick, counted from the last restart of the divider.
- R5: On an update, when the gap between duty and target exceeds both the band and the step, the duty moves toward the target by `stepSel`+1 LSB.
- R6: A step never passes the target. When the gap exceeds the band but is at most `stepSel`+1, the update sets the duty equal to the target.
- R7: When the absolute gap is less than or equal to `bandSel` LSB, an update leaves the duty unchanged. Band code 0 therefore requires an exact match.
- R8: A change of `rateSel` restarts the divider, so the next update comes after a full new interval of base ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | One-cycle pulse every 1/16 s |
| rampEn | input | 1 | 1 = slew gradually, 0 = copy target |
| rateSel | input | 3 | Interval code, 2^(7−code) base ticks |
| stepSel | input | 2 | Step size minus one, in LSB |
| bandSel | input | 2 | Stop band, in LSB |
| targetDuty | input | 8 | Requested duty |
| duty | output | 8 | Current duty |

## Verification
The assertions assume that `baseTick` is a single-cycle pulse with idle cycles between pulses. They also assume that a step or load is judged against the target value present at the edge that takes it, so the target must not be changed in a way that depends on the same edge. The bench meets these assumptions. It changes the target, the codes and the mode only while no tick is pending, and it waits two idle clocks after any rate change before issuing ticks. The expected duty is then a plain function of how many ticks have been issued since the restart.

// File: rtl/duty_slew_pkg.sv
package duty_slew_pkg;
  // Strobes passed from the interval control to the duty datapath
  typedef struct packed {
    logic load;    // copy target into duty
    logic stepGo;  // take one bounded step toward target
  } strobe_t;
endpackage

// File: rtl/duty_slew_ctrl.sv
module duty_slew_ctrl
  import duty_slew_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  logic              rampEn,
  input  logic [RATE_W-1:0] rateSel,
  output strobe_t           strobe
);
  localparam int CNT_W = (2 ** RATE_W) - 1;

  logic [RATE_W-1:0] rateQ;
  logic [CNT_W-1:0]  tickCnt;
  logic [CNT_W:0]    span;
  logic [CNT_W-1:0]  lastCnt;
  logic              rateChg;
  logic              update;

  // interval = 2^(max - rate); max is all ones so the exponent is ~rateQ
  always_comb begin
    span    = {{CNT_W{1'b0}}, 1'b1} << (~rateQ);
    lastCnt = CNT_W'(span - 1'b1);
    rateChg = (rateSel != rateQ);
    update  = baseTick && !rateChg && (tickCnt == lastCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateQ   <= '0;
      tickCnt <= '0;
    end else begin
      rateQ <= rateSel;
      if (rateChg)       tickCnt <= '0;
      else if (update)   tickCnt <= '0;
      else if (baseTick) tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.load   = !rampEn;
    strobe.stepGo = rampEn && update;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= lastCnt); // R4
  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    rateChg |=> (tickCnt == '0)); // R8
  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepGo |-> (baseTick && rampEn)); // R3
endmodule

// File: rtl/duty_slew_dp.sv
module duty_slew_dp
  import duty_slew_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int STEP_W = 2,
  parameter int BAND_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DUTY_W-1:0] targetDuty,
  input  logic [STEP_W-1:0] stepSel,
  input  logic [BAND_W-1:0] bandSel,
  output logic [DUTY_W-1:0] duty
);
  logic              goUp;
  logic [DUTY_W-1:0] gap;
  logic [DUTY_W-1:0] stepAmt;
  logic [DUTY_W-1:0] bandAmt;
  logic [DUTY_W-1:0] nextStep;

  always_comb begin
    goUp     = targetDuty > duty;
    gap      = goUp ? (targetDuty - duty) : (duty - targetDuty);
    stepAmt  = DUTY_W'(stepSel) + 1'b1;
    bandAmt  = DUTY_W'(bandSel);
    if (gap <= stepAmt) nextStep = targetDuty;
    else if (goUp)      nextStep = duty + stepAmt;
    else                nextStep = duty - stepAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                duty <= '0;
    else if (strobe.load)                     duty <= targetDuty;
    else if (strobe.stepGo && gap > bandAmt)  duty <= nextStep;
  end

  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (duty == $past(targetDuty))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.stepGo) |=> $stable(duty)); // R3
  AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepGo && !strobe.load && duty < targetDuty)
      |=> (duty <= $past(targetDuty) && duty >= $past(duty))); // R6
  AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepGo && !strobe.load && duty > targetDuty)
      |=> (duty >= $past(targetDuty) && duty <= $past(duty))); // R6
  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepGo && !strobe.load && gap <= bandAmt) |=> $stable(duty)); // R7
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepGo && !strobe.load && gap > stepAmt && gap > bandAmt)
      |=> ((duty > $past(duty) ? duty - $past(duty) : $past(duty) - duty)
           == $past(stepAmt))); // R5
endmodule

// File: rtl/duty_slew.sv
module duty_slew
  import duty_slew_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int RATE_W = 3,
  parameter int STEP_W = 2,
  parameter int BAND_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  logic              rampEn,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [STEP_W-1:0] stepSel,
  input  logic [BAND_W-1:0] bandSel,
  input  logic [DUTY_W-1:0] targetDuty,
  output logic [DUTY_W-1:0] duty
);
  strobe_t strobe;

  duty_slew_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .rampEn(rampEn),
    .rateSel(rateSel), .strobe(strobe)
  );

  duty_slew_dp #(.DUTY_W(DUTY_W), .STEP_W(STEP_W), .BAND_W(BAND_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .targetDuty(targetDuty),
    .stepSel(stepSel), .bandSel(bandSel), .duty(duty)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rstN |=> (duty == '0)); // R1
endmodule

// File: tb/sim_duty_slew.sv
`timescale 1ns/1ps
module sim_duty_slew;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseTick = 1'b0;
  logic       rampEn = 1'b0;
  logic [2:0] rateSel = 3'd0;
  logic [1:0] stepSel = 2'd0;
  logic [1:0] bandSel = 2'd0;
  logic [7:0] targetDuty = 8'd0;
  logic [7:0] duty;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  duty_slew u0 (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .rampEn(rampEn),
    .rateSel(rateSel), .stepSel(stepSel), .bandSel(bandSel),
    .targetDuty(targetDuty), .duty(duty)
  );

  task automatic chk(input int exp, input string req);
    vectors++;
    if (duty !== 8'(exp)) begin
      fails++;
      $display("FAIL %s duty=%0d expected=%0d", req, duty, exp);
    end
  endtask

  // expected single update, per R5, R6, R7
  function automatic int stepToward(int cur, int tgt, int s, int b);
    int g = (tgt > cur) ? tgt - cur : cur - tgt;
    if (g <= b) return cur;
    if (g <= s) return tgt;
    return (tgt > cur) ? cur + s : cur - s;
  endfunction

  task automatic tick();
    @(negedge clk) baseTick = 1'b1;
    @(negedge clk) baseTick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // preload t0 directly, then slew to t1 with a freshly restarted divider
  task automatic runRamp(input int rate, input int stp, input int band,
                         input int t0, input int t1);
    int exp, tc, interval, extra, g;
    rampEn = 1'b0; targetDuty = 8'(t0); rateSel = 3'(rate ^ 1);
    idle(2);
    chk(t0, "R2");
    rateSel = 3'(rate); stepSel = 2'(stp); bandSel = 2'(band);
    targetDuty = 8'(t1); rampEn = 1'b1;
    idle(2);
    chk(t0, "R3");
    exp = t0; tc = 0; extra = 0; interval = 1 << (7 - rate);
    while (extra < 2) begin
      tick();
      tc++;
      if (tc == interval) begin
        tc = 0;
        g = (t1 > exp) ? t1 - exp : exp - t1;
        if (g <= band) extra++;
        exp = stepToward(exp, t1, stp + 1, band);
      end
      chk(exp, "R4_R5_R6_R7");
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog duty=%0d expected=finish", duty);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk(0, "R1");
    rstN = 1'b1;
    idle(2);
    chk(0, "R1");

    // R2: direct copy, no ticks
    targetDuty = 8'd173; idle(1); chk(173, "R2");
    targetDuty = 8'd4;   idle(1); chk(4, "R2");

    // full sweep at fastest rate: every step and band code, several pairs
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 4; b++) begin
        runRamp(7, s, b, 0, 60);
        runRamp(7, s, b, 200, 130);
        runRamp(7, s, b, 100, 103);
        runRamp(7, s, b, 10, 10);
        runRamp(7, s, b, 255, 250);
      end
    // full-scale spans
    runRamp(7, 0, 0, 0, 255);
    runRamp(7, 3, 0, 255, 0);
    // every rate code (R4)
    for (int r = 0; r < 7; r++) runRamp(r, 3, 0, 0, 20);

    // R8: rate change mid-interval restarts the divider
    rampEn = 1'b0; targetDuty = 8'd0; rateSel = 3'd5; idle(2);
    stepSel = 2'd3; bandSel = 2'd0; targetDuty = 8'd100; rampEn = 1'b1;
    rateSel = 3'd4; idle(2); rateSel = 3'd5; idle(2);
    tick(); tick(); chk(0, "R8");
    rateSel = 3'd6; idle(2);
    tick(); chk(0, "R8");
    tick(); chk(4, "R8");

    // R2: turning slewing off mid-ramp jumps to target
    rampEn = 1'b0; idle(1); chk(100, "R2");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule